// File: doc/BRIEF.md
# Upstream Request Tag Allocator and Translator

This block sits between the bridge side of a graphics port and the upstream link of a tunnel device. Each request it accepts carries a source (graphics path or legacy PCI path), a priority, and a kind: write, read, flush or fence. The block turns the request into an upstream link request descriptor. The descriptor holds a command, a posted flag, the request's pass-posted-writes ordering bit, the expected response ordering bit, a transaction tag and a source unit ID.

Non-posted graphics requests take tags from a rolling pointer that runs through a bounded pool. Each tag stays busy until a response carrying it comes back on the response-return channel. The PCI path has a single reserved tag, so it can have only one non-posted request in flight. A fence is swallowed: it emits nothing, but it holds every later request until all reads that are in flight have been answered. Input flow control is a valid/ready handshake. The descriptor leaves through a register one cycle after acceptance.

Top module: `uprq_xlate`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 for every request kind, and the first non-posted graphics request is given tag 0.
- R2: Non-posted graphics requests (reads and flushes) get tags 0, 1, …, NTAGS-1 (27 by default) in order, and the sequence then wraps to 0. The pointer advances only on such requests.
- R3: A graphics tag stays busy from issue until a response with that tag arrives. While the tag at the pointer is busy, `in_ready` is 0 for non-posted graphics requests, so no more than NTAGS are in flight. Release of a different tag does not end the stall.
- R4: Non-posted PCI-path requests always carry tag NTAGS (28) and unit ID BASE_UNIT+1. A second such request waits with `in_ready`=0 until a response with tag 28 returns.
- R5: Every graphics-path request carries unit ID BASE_UNIT+2 (6 by default). Unit ID BASE_UNIT is never emitted.
- R6: A write gives `out_cmd`=0 (sized write), `out_posted`=1 and `out_tag`=0, and it never waits for a tag. `out_passpw` equals the priority bit for graphics writes and is 0 for PCI-path writes.
- R7: A read gives `out_cmd`=1 (sized read), `out_posted`=0 and `out_rsp_passpw`=1. `out_passpw` equals the priority bit for graphics reads and is 0 for PCI-path reads.
- R8: A flush (`in_kind`=2) gives `out_cmd`=2, `out_posted`=0, `out_passpw`=0 and `out_rsp_passpw`=0, whatever the priority. It takes a tag like a read does.
- R9: A fence (`in_kind`=3) is always accepted when no fence is pending, and it emits no descriptor. If any read is in flight at that moment, `in_ready` is 0 for all kinds from the next cycle until the cycle after the last such read's response. Outstanding flushes and writes do not hold a fence.
- R10: Each accepted non-fence request gives exactly one `out_valid` pulse, in the cycle after acceptance. No pulse appears without an acceptance.
- R11: A response whose tag is not busy, or whose value is above 28, changes no state.

Input kind encoding: 0 write, 1 read, 2 flush, 3 fence. `in_pci`=1 selects the PCI path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_pci | input | 1 | 1 = PCI path, 0 = graphics path |
| in_hipri | input | 1 | High-priority request |
| in_kind | input | 2 | 0 write, 1 read, 2 flush, 3 fence |
| rsp_valid | input | 1 | Response returned |
| rsp_tag | input | TAG_W (5) | Tag of returned response |
| out_valid | output | 1 | Descriptor valid (one cycle) |
| out_cmd | output | 2 | 0 sized write, 1 sized read, 2 flush |
| out_posted | output | 1 | Posted channel |
| out_passpw | output | 1 | Request pass-posted-writes bit |
| out_rsp_passpw | output | 1 | Expected response pass-posted-writes bit |
| out_tag | output | TAG_W (5) | Transaction tag |
| out_unit | output | UNIT_W (5) | Source unit ID |

## Verification
A busy map that keeps a stale bit shows up as `in_ready` stuck low for one request kind. A bit lost too early shows up as a tag being reissued before its response. Either one is visible in the first cycle the pointer reaches the slot. A pointer error shows in the next graphics read or flush descriptor, one cycle after acceptance. Fence misbehaviour is seen in the `in_ready` of the cycle right after the fence and right after the last read response. The bench follows a reference model of the busy map, pointer and fence state, and it compares `in_ready` every cycle and every descriptor field on every pulse.

// File: rtl/uprq_pkg.sv
package uprq_pkg;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0,
    K_READ  = 2'd1,
    K_FLUSH = 2'd2,
    K_FENCE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    C_WRSZ  = 2'd0,
    C_RDSZ  = 2'd1,
    C_FLUSH = 2'd2
  } cmd_e;

  typedef struct packed {
    cmd_e cmd;
    logic posted;
    logic passpw;
    logic rsp_passpw;
    logic nonposted;
    logic is_read;
    logic is_fence;
  } xlat_t;

endpackage

// File: rtl/uprq_classify.sv
module uprq_classify
  import uprq_pkg::*;
(
  input  logic       pci,
  input  logic       hipri,
  input  logic [1:0] kind,
  output xlat_t      xl
);
  always_comb begin
    xl            = '0;
    xl.cmd        = C_WRSZ;
    unique case (kind_e'(kind))
      K_WRITE: begin
        xl.cmd    = C_WRSZ;
        xl.posted = 1'b1;
        xl.passpw = hipri & ~pci;
      end
      K_READ: begin
        xl.cmd        = C_RDSZ;
        xl.passpw     = hipri & ~pci;
        xl.rsp_passpw = 1'b1;
        xl.nonposted  = 1'b1;
        xl.is_read    = 1'b1;
      end
      K_FLUSH: begin
        xl.cmd       = C_FLUSH;
        xl.nonposted = 1'b1;
      end
      default: begin
        xl.is_fence = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/uprq_tag_pool.sv
module uprq_tag_pool #(
  parameter int NTAGS = 28,
  localparam int SLOTS = NTAGS + 1,
  localparam int TAG_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_gfx,
  input  logic             take_pci,
  input  logic             take_read,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic [TAG_W-1:0] gfx_tag,
  output logic             gfx_free,
  output logic             pci_free,
  output logic             reads_next_any
);
  logic [SLOTS-1:0] busy_q, busy_d;
  logic [SLOTS-1:0] rd_q, rd_d;
  logic [TAG_W-1:0] ptr_q;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [TAG_W-1:0] IDX = TAG_W'(i);
    logic clr, set;
    assign clr = rsp_valid && (rsp_tag == IDX);
    if (i < NTAGS) begin : g_gfx
      assign set = take_gfx && (ptr_q == IDX);
    end else begin : g_pci
      assign set = take_pci;
    end
    always_comb begin
      busy_d[i] = busy_q[i];
      rd_d[i]   = rd_q[i];
      if (clr) begin
        busy_d[i] = 1'b0;
        rd_d[i]   = 1'b0;
      end
      if (set) begin
        busy_d[i] = 1'b1;
        rd_d[i]   = take_read;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      rd_q   <= '0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      if (take_gfx)
        ptr_q <= (ptr_q == TAG_W'(NTAGS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign gfx_tag        = ptr_q;
  assign gfx_free       = ~busy_q[ptr_q];
  assign pci_free       = ~busy_q[NTAGS];
  assign reads_next_any = |rd_d;
endmodule

// File: rtl/uprq_xlate.sv
module uprq_xlate
  import uprq_pkg::*;
#(
  parameter int NTAGS = 28,
  parameter int UNIT_W = 5,
  parameter int BASE_UNIT = 4,
  localparam int TAG_W = $clog2(NTAGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_pci,
  input  logic              in_hipri,
  input  logic [1:0]        in_kind,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  output logic              out_valid,
  output logic [1:0]        out_cmd,
  output logic              out_posted,
  output logic              out_passpw,
  output logic              out_rsp_passpw,
  output logic [TAG_W-1:0]  out_tag,
  output logic [UNIT_W-1:0] out_unit
);
  localparam logic [UNIT_W-1:0] PCI_UNIT = UNIT_W'(BASE_UNIT + 1);
  localparam logic [UNIT_W-1:0] GFX_UNIT = UNIT_W'(BASE_UNIT + 2);
  localparam logic [TAG_W-1:0]  PCI_TAG  = TAG_W'(NTAGS);

  xlat_t            xl;
  logic             fence_wait_q;
  logic             accept, take_gfx, take_pci, tag_ok;
  logic [TAG_W-1:0] gfx_tag;
  logic             gfx_free, pci_free, reads_next_any;

  uprq_classify u_cls (
    .pci   (in_pci),
    .hipri (in_hipri),
    .kind  (in_kind),
    .xl    (xl)
  );

  uprq_tag_pool #(.NTAGS(NTAGS)) u_pool (
    .clk            (clk),
    .rst            (rst),
    .take_gfx       (take_gfx),
    .take_pci       (take_pci),
    .take_read      (xl.is_read),
    .rsp_valid      (rsp_valid),
    .rsp_tag        (rsp_tag),
    .gfx_tag        (gfx_tag),
    .gfx_free       (gfx_free),
    .pci_free       (pci_free),
    .reads_next_any (reads_next_any)
  );

  always_comb begin
    if (!xl.nonposted) tag_ok = 1'b1;
    else if (in_pci)   tag_ok = pci_free;
    else               tag_ok = gfx_free;
  end

  assign in_ready = ~fence_wait_q & tag_ok;
  assign accept   = in_valid & in_ready;
  assign take_gfx = accept & xl.nonposted & ~in_pci;
  assign take_pci = accept & xl.nonposted & in_pci;

  always_ff @(posedge clk) begin
    if (rst) begin
      fence_wait_q   <= 1'b0;
      out_valid      <= 1'b0;
      out_cmd        <= '0;
      out_posted     <= 1'b0;
      out_passpw     <= 1'b0;
      out_rsp_passpw <= 1'b0;
      out_tag        <= '0;
      out_unit       <= '0;
    end else begin
      fence_wait_q <= (fence_wait_q | (accept & xl.is_fence)) & reads_next_any;
      out_valid    <= accept & ~xl.is_fence;
      if (accept && !xl.is_fence) begin
        out_cmd        <= xl.cmd;
        out_posted     <= xl.posted;
        out_passpw     <= xl.passpw;
        out_rsp_passpw <= xl.rsp_passpw;
        out_unit       <= in_pci ? PCI_UNIT : GFX_UNIT;
        if (!xl.nonposted) out_tag <= '0;
        else if (in_pci)   out_tag <= PCI_TAG;
        else               out_tag <= gfx_tag;
      end
    end
  end
endmodule

// File: rtl/uprq_xlate_chk.sv
module uprq_xlate_chk #(
  parameter int NTAGS = 28,
  parameter int UNIT_W = 5,
  parameter int BASE_UNIT = 4,
  localparam int TAG_W = $clog2(NTAGS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic              out_valid,
  input logic [1:0]        out_cmd,
  input logic              out_posted,
  input logic              out_passpw,
  input logic              out_rsp_passpw,
  input logic [TAG_W-1:0]  out_tag,
  input logic [UNIT_W-1:0] out_unit
);
  localparam logic [UNIT_W-1:0] PCI_UNIT = UNIT_W'(BASE_UNIT + 1);
  localparam logic [UNIT_W-1:0] GFX_UNIT = UNIT_W'(BASE_UNIT + 2);

  p_pulse_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready && in_kind != 2'd3));

  p_fence_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_kind == 2'd3) |=> !out_valid);

  p_gfx_tag_range_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_posted && out_unit == GFX_UNIT) |-> (out_tag < TAG_W'(NTAGS)));

  p_pci_tag_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_posted && out_unit == PCI_UNIT) |-> (out_tag == TAG_W'(NTAGS)));

  p_unit_legal_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_unit == PCI_UNIT || out_unit == GFX_UNIT));

  p_write_posted_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 2'd0) |-> (out_posted && out_tag == '0));

  p_read_rsp_pw_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 2'd1) |-> (out_rsp_passpw && !out_posted));

  p_flush_pw_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cmd == 2'd2) |-> (!out_passpw && !out_posted));
endmodule

bind uprq_xlate uprq_xlate_chk #(
  .NTAGS(NTAGS), .UNIT_W(UNIT_W), .BASE_UNIT(BASE_UNIT)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_kind(in_kind), .out_valid(out_valid), .out_cmd(out_cmd),
  .out_posted(out_posted), .out_passpw(out_passpw),
  .out_rsp_passpw(out_rsp_passpw), .out_tag(out_tag), .out_unit(out_unit)
);

// File: tb/sim_uprq_xlate.sv
module sim_uprq_xlate;
  localparam int NT = 28;
  localparam int TW = 5;
  localparam int UW = 5;
  localparam int BU = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_pci = 1'b0, in_hipri = 1'b0;
  logic [1:0] in_kind = 2'd1;
  logic rsp_valid = 1'b0;
  logic [TW-1:0] rsp_tag = '0;
  logic in_ready, out_valid, out_posted, out_passpw, out_rsp_passpw;
  logic [1:0] out_cmd;
  logic [TW-1:0] out_tag;
  logic [UW-1:0] out_unit;

  always #10 clk = ~clk;

  uprq_xlate #(.NTAGS(NT), .UNIT_W(UW), .BASE_UNIT(BU)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pci(in_pci), .in_hipri(in_hipri), .in_kind(in_kind),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .out_valid(out_valid),
    .out_cmd(out_cmd), .out_posted(out_posted), .out_passpw(out_passpw),
    .out_rsp_passpw(out_rsp_passpw), .out_tag(out_tag), .out_unit(out_unit)
  );

  int n_cmp = 0, n_bad = 0;
  logic [NT:0] m_busy = '0, m_rd = '0;
  int m_ptr = 0;
  bit m_fw = 0;

  task automatic chk(bit ok, string r, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic bit exp_ready(bit pci, int kind);
    if (m_fw) return 0;
    if (kind == 0 || kind == 3) return 1;
    return pci ? !m_busy[NT] : !m_busy[m_ptr];
  endfunction

  function automatic string pick(string req, string dflt);
    return (req != "") ? req : dflt;
  endfunction

  task automatic step(bit v, bit pci, bit pri, int kind, bit rv, int rtag, string req);
    bit er, acc;
    int e_cmd, e_tag, e_unit;
    bit e_post, e_pw, e_rpw;
    in_valid = v; in_pci = pci; in_hipri = pri; in_kind = kind[1:0];
    rsp_valid = rv; rsp_tag = rtag[TW-1:0];
    er = exp_ready(pci, kind);
    #1;
    chk(in_ready === er, pick(req, m_fw ? "R9" : (pci ? "R4" : "R3")), "in_ready", in_ready, er);
    acc = v && er;
    e_cmd = kind; e_post = (kind == 0);
    e_pw = (kind <= 1) && !pci && pri;
    e_rpw = (kind == 1);
    e_tag = (kind == 0) ? 0 : (pci ? NT : m_ptr);
    e_unit = pci ? BU + 1 : BU + 2;
    @(posedge clk);
    if (rv && rtag <= NT) begin m_busy[rtag] = 0; m_rd[rtag] = 0; end
    if (acc && (kind == 1 || kind == 2)) begin
      if (pci) begin m_busy[NT] = 1; m_rd[NT] = (kind == 1); end
      else begin
        m_busy[m_ptr] = 1; m_rd[m_ptr] = (kind == 1);
        m_ptr = (m_ptr == NT - 1) ? 0 : m_ptr + 1;
      end
    end
    m_fw = (m_fw || (acc && kind == 3)) && (m_rd != 0);
    @(negedge clk);
    in_valid = 0; rsp_valid = 0;
    chk(out_valid === (acc && kind != 3), pick(req, kind == 3 ? "R9" : "R10"), "out_valid",
        out_valid, acc && kind != 3);
    if (acc && kind != 3) begin
      string rk;
      rk = (kind == 0) ? "R6" : (kind == 1) ? "R7" : "R8";
      chk(out_cmd == e_cmd, pick(req, rk), "out_cmd", out_cmd, e_cmd);
      chk(out_posted == e_post, pick(req, rk), "out_posted", out_posted, e_post);
      chk(out_passpw == e_pw, pick(req, rk), "out_passpw", out_passpw, e_pw);
      chk(out_rsp_passpw == e_rpw, pick(req, rk), "out_rsp_passpw", out_rsp_passpw, e_rpw);
      chk(out_tag == e_tag, pick(req, pci ? "R4" : "R2"), "out_tag", out_tag, e_tag);
      chk(out_unit == e_unit, pick(req, pci ? "R4" : "R5"), "out_unit", out_unit, e_unit);
    end
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid === 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(in_ready === 1'b1, "R1", "reset in_ready", in_ready, 1);
    // R1 first tag is 0, then R2 increment through 27
    step(1, 0, 0, 1, 0, 0, "R1");
    for (int i = 1; i < NT; i++) step(1, 0, (i % 2) == 1, 1, 0, 0, "R2");
    // R3 pool full: pointer slot 0 busy
    step(1, 0, 0, 1, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 0, "R6");          // writes never wait
    step(0, 0, 0, 1, 1, 5, "R3");          // release other tag
    step(1, 0, 0, 1, 0, 0, "R3");          // still stalled
    step(1, 0, 0, 2, 1, 30, "R11");        // out-of-range response ignored
    step(1, 0, 0, 1, 1, 5, "R11");         // repeat response to free tag ignored
    step(0, 0, 0, 1, 1, 0, "R3");          // release pointer slot
    step(1, 0, 0, 1, 0, 0, "R2");          // wraps to tag 0
    // drain everything
    for (int t = 0; t < NT; t++) step(0, 0, 0, 1, 1, t, "R3");
    // R9 flush outstanding does not hold a fence
    step(1, 0, 1, 2, 0, 0, "R8");
    step(1, 0, 0, 3, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    // R9 read outstanding holds fence
    step(1, 0, 1, 1, 0, 0, "R7");
    step(1, 1, 0, 3, 0, 0, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    step(1, 1, 0, 1, 1, m_ptr - 1, "R9");
    step(1, 0, 0, 0, 0, 0, "R9");
    // R4 PCI single slot
    step(1, 1, 1, 1, 0, 0, "R4");
    step(1, 1, 0, 2, 0, 0, "R4");
    step(1, 0, 1, 1, 0, 0, "R5");
    step(1, 1, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 1, NT, "R4");
    step(1, 1, 1, 2, 0, 0, "R8");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int k, rt;
      bit v, pc, pr, rv;
      k = $urandom % 4; pc = ($urandom % 4) == 0; pr = $urandom % 2;
      v = ($urandom % 4) != 0; rv = $urandom % 2; rt = $urandom % 32;
      step(v, pc, pr, k, rv, rt, "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule